// File: doc/BRIEF.md
# Two-Section Decade Counter with Clear and Nine-Preset

The block is a four-bit counter built from two independent sections on one system clock. A divide-by-two section owns output bit `q[0]`, and a divide-by-five section owns `q[3:1]`. Each section advances on its own count-enable input, which is sampled on the rising clock edge in place of a separate clock pin. A two-input AND of clear lines forces the count to zero. A two-input AND of preset lines forces it to nine, and the preset wins when both pairs are asserted.

A mode input chooses how the sections are linked. In independent mode the sections do not interact. In decade mode the falling edge of `q[0]` steps the five-section, which gives BCD 0 to 9. In bi-quinary mode the five-section's wrap steps the two-section, so `q[0]` is a symmetric tenth of the input rate. In divide-by-six mode the decade order wraps after five. When the count returns to zero in decade or divide-by-six mode, a one-cycle carry pulse is raised. That pulse can drive the decade enable of a second unit to count 00 to 99.

Top module: `dual_decade_counter`

## Requirements
- R1: While `rst_n` is low, and on the first edge after its release, `q` is 0000 and `carry` is 0.
- R2: A rising edge with `set9_a` and `set9_b` both high loads `q` = 1001 (value nine) with `carry` 0, whatever the clear lines, the enables and the mode are.
- R3: A rising edge with `clr_a` and `clr_b` both high, and the preset pair not both high, loads `q` = 0000. A single high clear line has no effect on counting.
- R4: Mode 2'b00 (independent): `en_a` toggles `q[0]`, and `en_b` steps `q[3:1]` through 000, 001, 010, 011, 100 and back to 000.
- R5: Mode 2'b01 (decade): each `en_a` edge adds one to `q` read as a binary number, from 0 through 9 and then back to 0. `en_b` has no effect.
- R6: In modes 2'b01 and 2'b11, `carry` is high for exactly the one cycle in which `q` has just returned to 0000 by counting. It is never high in modes 2'b00 and 2'b10.
- R7: Mode 2'b10 (bi-quinary): each `en_b` edge steps `q[3:1]` modulo five. The wrap from 100 toggles `q[0]`. From 0000 the values run 0,2,4,6,8,1,3,5,7,9, so `q[0]` is high for five of every ten steps. `en_a` has no effect.
- R8: Mode 2'b11 (divide by six): `en_a` counts 0 through 5 and then wraps to 0, which gives one carry every six enables. A count of 9, reached through the preset, also wraps to 0.
- R9: Two units, where the upper unit's `en_a` is the lower unit's `carry` and both are in decade mode, count 00 to 99 and return to 00 on the hundredth enable.
- R10: With no enable active and neither pair asserted, `q` holds its value and `carry` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 independent, 01 decade, 10 bi-quinary, 11 divide by six |
| en_a | input | 1 | Count enable of the divide-by-two section |
| en_b | input | 1 | Count enable of the divide-by-five section |
| clr_a | input | 1 | Clear line, ANDed with clr_b |
| clr_b | input | 1 | Clear line, ANDed with clr_a |
| set9_a | input | 1 | Preset line, ANDed with set9_b |
| set9_b | input | 1 | Preset line, ANDed with set9_a |
| q | output | 4 | Count; q[0] from the two-section, q[3:1] from the five-section |
| carry | output | 1 | One-cycle pulse on a return to zero in modes 01 and 11 |

## Verification
Every result of a single unit is due on the first rising edge after its inputs are applied. The bench drives inputs just after a falling edge and compares `q` and `carry` with its own model at the next falling edge. In a cascade the upper digit changes one edge later than the lower digit's wrap, because it counts the registered carry. The cascade check therefore follows each enable pulse with one idle cycle before it reads both digits. Random stimulus across all modes is compared cycle by cycle with a bench-side next-state function.

// File: rtl/dual_decade_counter.sv
module dual_decade_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       en_a,
  input  logic       en_b,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       set9_a,
  input  logic       set9_b,
  output logic [3:0] q,
  output logic       carry
);
  localparam logic [1:0] M_SPLIT = 2'b00;
  localparam logic [1:0] M_BCD   = 2'b01;
  localparam logic [1:0] M_BIQ   = 2'b10;
  localparam logic [1:0] M_SIX   = 2'b11;
  localparam logic [2:0] D5_TOP  = 3'd4;

  logic       two_r;
  logic [2:0] five_r;
  logic       carry_r;

  wire preset = set9_a & set9_b;
  wire clear  = clr_a & clr_b & ~preset;
  wire five_top = (five_r >= D5_TOP);

  logic       step_two, step_five, six_wrap;
  logic       two_nx;
  logic [2:0] five_nx;

  always_comb begin
    step_two  = 1'b0;
    step_five = 1'b0;
    unique case (mode)
      M_SPLIT: begin step_two = en_a; step_five = en_b; end
      M_BCD, M_SIX: begin step_two = en_a; step_five = en_a & two_r; end
      M_BIQ: begin step_five = en_b; step_two = en_b & five_top; end
      default: ;
    endcase
  end

  assign six_wrap = (mode == M_SIX) & en_a & two_r & (five_r == 3'd2);

  always_comb begin
    two_nx  = two_r ^ step_two;
    five_nx = five_r;
    if (step_five) five_nx = five_top ? 3'd0 : five_r + 3'd1;
    if (six_wrap) begin
      two_nx  = 1'b0;
      five_nx = 3'd0;
    end
  end

  wire carry_nx = mode[0] & en_a & two_r & (five_nx == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      two_r   <= 1'b0;
      five_r  <= 3'd0;
      carry_r <= 1'b0;
    end else if (preset) begin
      two_r   <= 1'b1;
      five_r  <= D5_TOP;
      carry_r <= 1'b0;
    end else if (clear) begin
      two_r   <= 1'b0;
      five_r  <= 3'd0;
      carry_r <= 1'b0;
    end else begin
      two_r   <= two_nx;
      five_r  <= five_nx;
      carry_r <= carry_nx;
    end
  end

  assign q     = {five_r, two_r};
  assign carry = carry_r;
endmodule

module dual_decade_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       en_a,
  input logic       en_b,
  input logic       clr_a,
  input logic       clr_b,
  input logic       set9_a,
  input logic       set9_b,
  input logic [3:0] q,
  input logic       carry
);
  wire pre = set9_a & set9_b;
  wire clr = clr_a & clr_b;

  a_r2_preset_nine: assert property (@(posedge clk) disable iff (!rst_n)
    pre |=> (q == 4'd9) && !carry);

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !pre) |=> (q == 4'd0) && !carry);

  a_r4_five_range: assert property (@(posedge clk) disable iff (!rst_n)
    q[3:1] <= 3'd4);

  a_r5_bcd_ignores_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !en_a && !pre && !clr) |=> $stable(q));

  a_r6_carry_single: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> !carry);

  a_r6_carry_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (q == 4'd0));

  a_r7_biq_ignores_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !en_b && !pre && !clr) |=> $stable(q) && !carry);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a && !en_b && !pre && !clr) |=> $stable(q) && !carry);
endmodule

bind dual_decade_counter dual_decade_counter_chk u_chk (.*);

// File: tb/dual_decade_counter_bench.sv
module dual_decade_counter_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [1:0] mode;
  logic       en_a, en_b, clr_a, clr_b, set9_a, set9_b;
  logic [3:0] q;
  logic       carry;
  logic       up_clr;
  logic [3:0] up_q;
  logic       up_carry;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  dual_decade_counter u_dual_decade_counter (
    .clk(clk), .rst_n(rst_n), .mode(mode), .en_a(en_a), .en_b(en_b),
    .clr_a(clr_a), .clr_b(clr_b), .set9_a(set9_a), .set9_b(set9_b),
    .q(q), .carry(carry));

  dual_decade_counter u_upper (
    .clk(clk), .rst_n(rst_n), .mode(2'b01), .en_a(carry), .en_b(1'b0),
    .clr_a(up_clr), .clr_b(up_clr), .set9_a(1'b0), .set9_b(1'b0),
    .q(up_q), .carry(up_carry));

  function automatic logic [4:0] model_next(logic [3:0] cq, logic [1:0] md,
      logic ea, logic eb, logic s, logic c);
    logic a;
    logic [2:0] d;
    int v;
    if (s) return {1'b0, 4'd9};
    if (c) return {1'b0, 4'd0};
    a = cq[0];
    d = cq[3:1];
    v = cq;
    case (md)
      2'b00: begin
        if (ea) a = ~a;
        if (eb) d = (d == 3'd4) ? 3'd0 : d + 3'd1;
        return {1'b0, d, a};
      end
      2'b01: begin
        if (!ea) return {1'b0, cq};
        if (v == 9) return {1'b1, 4'd0};
        return {1'b0, 4'(v + 1)};
      end
      2'b10: begin
        if (eb) begin
          if (d == 3'd4) begin d = 3'd0; a = ~a; end
          else d = d + 3'd1;
        end
        return {1'b0, d, a};
      end
      default: begin
        if (!ea) return {1'b0, cq};
        if (v == 5 || v == 9) return {1'b1, 4'd0};
        return {1'b0, 4'(v + 1)};
      end
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    en_a = 0; en_b = 0; clr_a = 0; clr_b = 0; set9_a = 0; set9_b = 0;
  endtask

  task automatic do_clear();
    idle(); clr_a = 1; clr_b = 1; tick(); idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] mq;
    logic [4:0] nx;
    int ones;
    int carries;
    int seq[10];
    void'($urandom(32'h5eed_1234));
    seq = '{0, 2, 4, 6, 8, 1, 3, 5, 7, 9};
    rst_n = 0; mode = 2'b01; up_clr = 0; idle();
    repeat (3) @(negedge clk);
    chk("R1 q in reset", q, 0);
    chk("R1 carry in reset", carry, 0);
    rst_n = 1;
    tick();
    chk("R1 q after release", q, 0);

    // R2: preset beats clear and counting
    mode = 2'b01; en_a = 1; clr_a = 1; clr_b = 1; set9_a = 1; set9_b = 1;
    tick(); idle();
    chk("R2 preset over clear", q, 9);
    chk("R2 preset carry", carry, 0);

    // R3: single clear line has no effect; pair clears
    clr_a = 1; en_a = 1; tick(); idle();
    chk("R3 lone clear ignored (9->0 wrap)", q, 0);
    chk("R6 carry on wrap", carry, 1);
    tick();
    chk("R6 carry one cycle", carry, 0);
    en_a = 1; clr_b = 1; tick(); idle();
    chk("R3 lone clr_b ignored", q, 1);
    do_clear();
    chk("R3 pair clears", q, 0);

    // R10: hold
    repeat (4) tick();
    chk("R10 hold", q, 0);

    // R5: decade sweep with en_b toggling
    for (int i = 1; i <= 10; i++) begin
      en_a = 1; en_b = 1; tick(); idle();
      chk("R5 decade step", q, i % 10);
      chk("R6 carry only at wrap", carry, (i == 10) ? 1 : 0);
    end
    en_b = 1; tick(); idle();
    chk("R5 en_b ignored", q, 0);

    // R4: independent sections
    mode = 2'b00; do_clear();
    for (int i = 1; i <= 6; i++) begin
      en_b = 1; tick(); idle();
      chk("R4 five-section step", q[3:1], i % 5);
    end
    en_a = 1; tick(); idle();
    chk("R4 two-section toggle", q[0], 1);
    chk("R6 no carry in split", carry, 0);

    // R7: bi-quinary with en_a held high
    mode = 2'b10; do_clear();
    ones = 0;
    for (int i = 1; i <= 20; i++) begin
      en_b = 1; en_a = 1; tick(); idle();
      chk("R7 biquinary code", q, seq[i % 10]);
      if (q[0]) ones++;
    end
    chk("R7 q0 duty 10 of 20", ones, 10);
    en_a = 1; tick(); idle();
    chk("R7 en_a ignored", q, 0);

    // R8: divide by six
    mode = 2'b11; do_clear();
    carries = 0;
    for (int i = 1; i <= 12; i++) begin
      en_a = 1; tick(); idle();
      chk("R8 six count", q, i % 6);
      if (carry) carries++;
    end
    chk("R8 carries per 12", carries, 2);
    set9_a = 1; set9_b = 1; tick(); idle();
    en_a = 1; tick(); idle();
    chk("R8 nine wraps to zero", q, 0);

    // R9: two-digit cascade
    mode = 2'b01; up_clr = 1; do_clear(); up_clr = 0;
    for (int n = 1; n <= 100; n++) begin
      en_a = 1; tick(); idle(); tick();
      chk("R9 units digit", q, n % 10);
      chk("R9 tens digit", up_q, (n / 10) % 10);
    end

    // Random phase against model
    do_clear();
    mq = q;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) mode = 2'($urandom_range(0, 3));
      en_a = 1'($urandom_range(0, 1));
      en_b = 1'($urandom_range(0, 1));
      clr_a = ($urandom_range(0, 5) == 0);
      clr_b = ($urandom_range(0, 5) == 0);
      set9_a = ($urandom_range(0, 5) == 0);
      set9_b = ($urandom_range(0, 5) == 0);
      nx = model_next(mq, mode, en_a, en_b, set9_a & set9_b, clr_a & clr_b);
      tick();
      chk("R10 random q vs model", q, nx[3:0]);
      chk("R6 random carry vs model", carry, nx[4]);
      mq = nx[3:0];
    end
    idle();
    finish_run();
  end
endmodule